// File: doc/BRIEF.md
# Two-Plane Tiled Pixel Writer

This unit places a single pixel into a bitmap stored at two bits per pixel, where the image is cut into 8x8 tiles and each pixel's two color bits sit in two neighbouring bytes. The byte holding bit 0 is called plane 0 and the byte right after it plane 1. A caller supplies the y coordinate, a color register, a two-bit option field and the visible height. The x coordinate is kept in a register inside the unit. For each plot the unit decides whether anything should be written, forms the tile byte address and the one-hot bit mask, and then does a read-modify-write of both plane bytes through a synchronous byte-wide RAM port.

The color can be dithered in a checkerboard pattern between the two nibbles of the color register. A color whose chosen nibble is zero can be treated as see-through. Once a plot finishes, x moves on by one so that a run of pixels along a line needs no address updates from the caller. A second operation reads back the 2-bit color of the pixel at the current x and the given y. It uses the same addressing and leaves x unchanged.

Top module: `bitplane_plot_unit`

## Requirements
- R1: Each accepted plot adds one to `xReg` (modulo 256), whether or not it writes anything. A read-pixel operation leaves `xReg` unchanged. A load through `xWrEn`/`xWrData` replaces `xReg` one cycle later.
- R2: When `yIn >= screenHeight`, a plot makes no memory access and keeps `busy` low. A read-pixel in that case answers with `pixValid` in the next cycle and `pixColor` = 0.
- R3: When `plotOpt[1]` is 1 and bit 0 of (x XOR y) is 1, the pixel color is `colorReg[7:4]`. In every other case it is `colorReg[3:0]`.
- R4: When `plotOpt[0]` is 0 and the chosen 4-bit color is zero, the plot is skipped with no memory write. When `plotOpt[0]` is 1, a zero color is written, which clears the pixel's bits.
- R5: The plane-0 byte address is (y>>3)*512 + (x>>3)*16 + (y&7)*2. This comes from 32 tile columns of 16 bytes each. Plane 1 sits at that address + 1.
- R6: The bit mask is 8'h80 >> (x&7). A plot changes only that bit in each of the two plane bytes.
- R7: Color bit 0 sets (1) or clears (0) the masked bit of plane 0. Color bit 1 does the same in plane 1. The port sequence on consecutive cycles is: read plane 0, read plane 1, write plane 0, write plane 1. Read data arrives one cycle after `memRe`.
- R8: `busy` is high for exactly the four cycles of a writing plot, starting the cycle after acceptance. A start presented while `busy` is high is ignored.
- R9: A read-pixel keeps `busy` high for three cycles and then pulses `pixValid` for one cycle. It returns `pixColor` = {masked bit of plane 1, masked bit of plane 0}.
- R10: When `startPlot` and `startRead` are both high, the plot is performed and no read-pixel result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPlot | input | 1 | Request a pixel plot (taken when idle) |
| startRead | input | 1 | Request a pixel read-back (taken when idle) |
| xWrEn | input | 1 | Load the x register |
| xWrData | input | 8 | Value for the x register |
| yIn | input | 8 | Pixel row |
| colorReg | input | 8 | Two color nibbles |
| plotOpt | input | 2 | Bit 0: write zero colors; bit 1: dither enable |
| screenHeight | input | 8 | Number of visible rows |
| memAddr | output | ADDR_W | RAM byte address |
| memRe | output | 1 | RAM read strobe |
| memWe | output | 1 | RAM write strobe |
| memWdata | output | 8 | RAM write data |
| memRdata | input | 8 | RAM read data, one cycle after memRe |
| busy | output | 1 | Read-modify-write or read-back in progress |
| xReg | output | 8 | Current x coordinate |
| pixValid | output | 1 | Read-back result valid (one cycle) |
| pixColor | output | 2 | Read-back color |

## Verification
The checker tests the following on every cycle:
- Writes happen only while busy.
- A read and a write never occur together.
- Back-to-back reads or writes go to adjacent plane addresses.
- A write run always follows a read.
- A read-back result never shows up while busy.
- The end of every writing plot advances x by exactly one.

Other behaviour can only be shown by the bench scenarios, which compare the RAM against a behavioural model:
- Which nibble dithering selects.
- Whether a zero color is skipped.
- The exact address and mask values, and that only the masked bit changes.
- The color returned by a read-back.
- That a start arriving mid-operation has no effect.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDA,
    ST_RDB,
    ST_FIN,
    ST_WRA,
    ST_WRB
  } bppState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchOp;  // capture operands at acceptance
    logic incX;     // advance the x register
    logic capLo;    // capture plane-0 byte from RAM
    logic capHi;    // capture plane-1 byte from RAM
    logic planeHi;  // address plane 1 instead of plane 0
    logic memRe;
    logic memWe;
    logic pixSet;   // publish read-back color
    logic pixZero;  // publish zero color (row out of range)
  } bppStrobe_t;

endpackage

// File: rtl/bpp_ctrl.sv
module bpp_ctrl
  import bpp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPlot,
  input  logic       startRead,
  input  logic       plotSkip,
  input  logic       yOutOfRange,
  output bppStrobe_t strobe,
  output logic       busy
);

  bppState_e state, stateNxt;
  logic      opRead, opReadNxt;

  always_comb begin
    strobe    = '0;
    stateNxt  = state;
    opReadNxt = opRead;
    unique case (state)
      ST_IDLE: begin
        if (startPlot) begin
          // plot has priority over a simultaneous read-back
          if (plotSkip) begin
            strobe.incX = 1'b1;
          end else begin
            strobe.latchOp = 1'b1;
            opReadNxt      = 1'b0;
            stateNxt       = ST_RDA;
          end
        end else if (startRead) begin
          if (yOutOfRange) begin
            strobe.pixZero = 1'b1;
          end else begin
            strobe.latchOp = 1'b1;
            opReadNxt      = 1'b1;
            stateNxt       = ST_RDA;
          end
        end
      end
      ST_RDA: begin
        strobe.memRe = 1'b1;
        stateNxt     = ST_RDB;
      end
      ST_RDB: begin
        strobe.memRe   = 1'b1;
        strobe.planeHi = 1'b1;
        strobe.capLo   = 1'b1;
        stateNxt       = opRead ? ST_FIN : ST_WRA;
      end
      ST_FIN: begin
        strobe.pixSet = 1'b1;
        stateNxt      = ST_IDLE;
      end
      ST_WRA: begin
        strobe.memWe = 1'b1;
        strobe.capHi = 1'b1;
        stateNxt     = ST_WRB;
      end
      ST_WRB: begin
        strobe.memWe   = 1'b1;
        strobe.planeHi = 1'b1;
        strobe.incX    = 1'b1;
        stateNxt       = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opRead <= 1'b0;
    end else begin
      state  <= stateNxt;
      opRead <= opReadNxt;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/bpp_datapath.sv
module bpp_datapath
  import bpp_pkg::*;
#(
  parameter int COORD_W    = 8,
  parameter int ADDR_W     = 16,
  parameter int TILE_BYTES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  bppStrobe_t         strobe,
  input  logic               xWrEn,
  input  logic [COORD_W-1:0] xWrData,
  input  logic [COORD_W-1:0] yIn,
  input  logic [7:0]         colorReg,
  input  logic [1:0]         plotOpt,
  input  logic [COORD_W-1:0] screenHeight,
  input  logic [7:0]         memRdata,
  output logic [COORD_W-1:0] xReg,
  output logic               plotSkip,
  output logic               yOutOfRange,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [7:0]         memWdata,
  output logic               pixValid,
  output logic [1:0]         pixColor
);

  localparam int TILE_SHIFT = 3;
  localparam int NUM_COLS   = 1 << (COORD_W - TILE_SHIFT);
  localparam int ROW_BYTES  = NUM_COLS * TILE_BYTES;

  // live decision on the operands present at acceptance
  logic       liveDither;
  logic [3:0] liveNibble;
  logic       liveClear;

  assign liveDither  = plotOpt[1] & (xReg[0] ^ yIn[0]);
  assign liveNibble  = liveDither ? colorReg[7:4] : colorReg[3:0];
  assign liveClear   = ~plotOpt[0] & (liveNibble == 4'd0);
  assign yOutOfRange = (yIn >= screenHeight);
  assign plotSkip    = yOutOfRange | liveClear;

  // latched operands
  logic [COORD_W-1:0] opX, opY;
  logic [1:0]         opColor;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opX     <= '0;
      opY     <= '0;
      opColor <= '0;
    end else if (strobe.latchOp) begin
      opX     <= xReg;
      opY     <= yIn;
      opColor <= liveNibble[1:0];
    end
  end

  // column offset table, one entry per tile column
  logic [ADDR_W-1:0] colTable [NUM_COLS];
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign colTable[c] = ADDR_W'(c * TILE_BYTES);
  end

  logic [ADDR_W-1:0] rowBase, lineOffs, tileAddr;
  logic [7:0]        bitMask;

  assign rowBase  = ADDR_W'(opY[COORD_W-1:TILE_SHIFT]) * ADDR_W'(ROW_BYTES);
  assign lineOffs = ADDR_W'({opY[TILE_SHIFT-1:0], 1'b0});
  assign tileAddr = rowBase + colTable[opX[COORD_W-1:TILE_SHIFT]] + lineOffs;
  assign bitMask  = 8'h80 >> opX[TILE_SHIFT-1:0];
  assign memAddr  = tileAddr + ADDR_W'(strobe.planeHi);

  // plane byte capture and merge
  logic [7:0] loByte, hiByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loByte <= '0;
      hiByte <= '0;
    end else begin
      if (strobe.capLo) loByte <= memRdata;
      if (strobe.capHi) hiByte <= memRdata;
    end
  end

  function automatic logic [7:0] mergeBit(input logic [7:0] b, input logic [7:0] m,
                                          input logic v);
    return v ? (b | m) : (b & ~m);
  endfunction

  assign memWdata = strobe.planeHi ? mergeBit(hiByte, bitMask, opColor[1])
                                   : mergeBit(loByte, bitMask, opColor[0]);

  // read-back result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      pixColor <= '0;
    end else begin
      pixValid <= strobe.pixSet | strobe.pixZero;
      if (strobe.pixSet)
        pixColor <= {|(memRdata & bitMask), |(loByte & bitMask)};
      else if (strobe.pixZero)
        pixColor <= '0;
    end
  end

  // x register: a load wins over the post-plot increment
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            xReg <= '0;
    else if (xWrEn)       xReg <= xWrData;
    else if (strobe.incX) xReg <= xReg + COORD_W'(1);
  end

endmodule

// File: rtl/bitplane_plot_unit.sv
module bitplane_plot_unit
  import bpp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPlot,
  input  logic              startRead,
  input  logic              xWrEn,
  input  logic [7:0]        xWrData,
  input  logic [7:0]        yIn,
  input  logic [7:0]        colorReg,
  input  logic [1:0]        plotOpt,
  input  logic [7:0]        screenHeight,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              busy,
  output logic [7:0]        xReg,
  output logic              pixValid,
  output logic [1:0]        pixColor
);

  bppStrobe_t strobe;
  logic       plotSkip, yOutOfRange;

  bpp_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPlot  (startPlot),
    .startRead  (startRead),
    .plotSkip   (plotSkip),
    .yOutOfRange(yOutOfRange),
    .strobe     (strobe),
    .busy       (busy)
  );

  bpp_datapath #(
    .COORD_W   (8),
    .ADDR_W    (ADDR_W),
    .TILE_BYTES(16)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .xWrEn       (xWrEn),
    .xWrData     (xWrData),
    .yIn         (yIn),
    .colorReg    (colorReg),
    .plotOpt     (plotOpt),
    .screenHeight(screenHeight),
    .memRdata    (memRdata),
    .xReg        (xReg),
    .plotSkip    (plotSkip),
    .yOutOfRange (yOutOfRange),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .pixValid    (pixValid),
    .pixColor    (pixColor)
  );

  assign memRe = strobe.memRe;
  assign memWe = strobe.memWe;

endmodule

// File: rtl/bpp_checker.sv
module bpp_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memRe,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              pixValid,
  input logic              xWrEn,
  input logic [7:0]        xReg
);

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R8

  AST_RE_WE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R7

  AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr == $past(memAddr) + ADDR_W'(1))); // R7

  AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && $past(memRe)) |-> (memAddr == $past(memAddr) + ADDR_W'(1))); // R5

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> $past(memRe)); // R7

  AST_PIX_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> !busy); // R9

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memWe) && !$past(xWrEn)) |-> (xReg == $past(xReg) + 8'd1)); // R1

endmodule

bind bitplane_plot_unit bpp_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .memRe   (memRe),
  .memWe   (memWe),
  .memAddr (memAddr),
  .pixValid(pixValid),
  .xWrEn   (xWrEn),
  .xReg    (xReg)
);

// File: tb/bitplane_plot_unit_tb_top.sv
`timescale 1ns/1ps
module bitplane_plot_unit_tb_top;

  localparam int ADDR_W   = 16;
  localparam int MEM_SIZE = 16384;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              startPlot = 1'b0, startRead = 1'b0, xWrEn = 1'b0;
  logic [7:0]        xWrData = '0, yIn = '0, colorReg = '0, screenHeight = 8'd200;
  logic [1:0]        plotOpt = '0;
  logic [ADDR_W-1:0] memAddr;
  logic              memRe, memWe, busy, pixValid;
  logic [7:0]        memWdata, memRdata, xReg;
  logic [1:0]        pixColor;

  always #2.5 clk = ~clk;

  bitplane_plot_unit #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .startPlot(startPlot), .startRead(startRead),
    .xWrEn(xWrEn), .xWrData(xWrData), .yIn(yIn), .colorReg(colorReg),
    .plotOpt(plotOpt), .screenHeight(screenHeight), .memAddr(memAddr),
    .memRe(memRe), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .xReg(xReg), .pixValid(pixValid), .pixColor(pixColor)
  );

  // bench RAM driven by the design, and the behavioural reference copy
  logic [7:0] ramDut [MEM_SIZE];
  logic [7:0] ramRef [MEM_SIZE];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_SIZE; i++) ramDut[i] <= 8'(i * 7 + 3);
      memRdata <= '0;
    end else begin
      if (memWe) ramDut[memAddr[13:0]] <= memWdata;
      if (memRe) memRdata <= ramDut[memAddr[13:0]];
    end
  end

  int  checks = 0, failures = 0;
  int  refX = 0;
  bit  finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int refAddr(input int x, input int y);
    return (y / 8) * 512 + (x / 8) * 16 + (y % 8) * 2;
  endfunction

  task automatic setX(input int v);
    @(negedge clk);
    xWrEn = 1'b1; xWrData = 8'(v);
    @(negedge clk);
    xWrEn = 1'b0;
    refX = v & 255;
    chk(xReg == 8'(v), "R1", "x load", xReg, v);
  endtask

  task automatic doPlot(input int y, input int color, input int opt, input int height,
                        input string req, input bit alsoRead = 1'b0,
                        input bit pokeBusy = 1'b0);
    int x, nib, a, busyLen;
    logic [7:0] m;
    bit skip;
    x    = refX;
    nib  = ((opt & 2) != 0 && ((x ^ y) & 1) != 0) ? ((color >> 4) & 15) : (color & 15);
    skip = (y >= height) || ((opt & 1) == 0 && nib == 0);
    a    = refAddr(x, y);
    m    = 8'h80 >> (x % 8);
    if (!skip) begin
      ramRef[a]   = ((nib & 1) != 0) ? (ramRef[a] | m)   : (ramRef[a] & ~m);
      ramRef[a+1] = ((nib & 2) != 0) ? (ramRef[a+1] | m) : (ramRef[a+1] & ~m);
    end
    busyLen = skip ? 0 : 4;
    @(negedge clk);
    yIn = 8'(y); colorReg = 8'(color); plotOpt = 2'(opt); screenHeight = 8'(height);
    startPlot = 1'b1; startRead = alsoRead;
    @(negedge clk);
    startPlot = 1'b0; startRead = 1'b0;
    for (int k = 0; k <= busyLen; k++) begin
      if (k > 0) @(negedge clk);
      if (pokeBusy && k == 1) begin startPlot = 1'b1; startRead = 1'b1; yIn = 8'(y + 1); end
      if (k == 2) begin startPlot = 1'b0; startRead = 1'b0; end
      chk(busy == (k < busyLen), req, "busy", busy, int'(k < busyLen));
    end
    refX = (x + 1) & 255;
    chk(xReg == 8'(refX), req, "x after plot", xReg, refX);
    chk(ramDut[a] == ramRef[a], req, "plane0", ramDut[a], ramRef[a]);
    chk(ramDut[a+1] == ramRef[a+1], req, "plane1", ramDut[a+1], ramRef[a+1]);
    chk(pixValid == 1'b0, req, "no read result", pixValid, 0);
  endtask

  task automatic doRead(input int y, input int height, input string req);
    int a, busyLen, expC;
    logic [7:0] m;
    bit oor;
    oor     = (y >= height);
    a       = refAddr(refX, y);
    m       = 8'h80 >> (refX % 8);
    expC    = oor ? 0 : ((((ramRef[a+1] & m) != 0) ? 2 : 0) + (((ramRef[a] & m) != 0) ? 1 : 0));
    busyLen = oor ? 0 : 3;
    @(negedge clk);
    yIn = 8'(y); screenHeight = 8'(height); startRead = 1'b1;
    @(negedge clk);
    startRead = 1'b0;
    for (int k = 0; k <= busyLen; k++) begin
      if (k > 0) @(negedge clk);
      chk(busy == (k < busyLen), req, "read busy", busy, int'(k < busyLen));
    end
    chk(pixValid == 1'b1, req, "pixValid", pixValid, 1);
    chk(pixColor == 2'(expC), req, "pixColor", pixColor, expC);
    chk(xReg == 8'(refX), "R1", "x after read", xReg, refX);
    @(negedge clk);
    chk(pixValid == 1'b0, req, "pixValid pulse", pixValid, 0);
  endtask

  initial begin
    int bad;
    for (int i = 0; i < MEM_SIZE; i++) ramRef[i] = 8'(i * 7 + 3);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 0 && memWe == 0 && memRe == 0, "R8", "reset idle", busy, 0);
    chk(pixValid == 0, "R9", "reset pixValid", pixValid, 0);
    chk(xReg == 0, "R1", "reset x", xReg, 0);

    setX(10);
    doPlot(5, 8'h03, 0, 200, "R7");   // both planes set
    doPlot(5, 8'h01, 0, 200, "R6");   // plane0 set, plane1 cleared
    doPlot(13, 8'h02, 1, 200, "R5");  // second tile row
    doPlot(5, 8'h30, 0, 200, "R4");   // transparent skip
    setX(10);
    doPlot(5, 8'h30, 1, 200, "R4");   // zero color written
    setX(3);
    doPlot(6, 8'h2C, 2, 200, "R3");   // x^y odd: upper nibble 2
    doPlot(6, 8'h2C, 2, 200, "R3");   // x^y even: lower nibble C
    doPlot(6, 8'h0D, 2, 200, "R3");   // odd: upper nibble 0 -> skip
    doPlot(200, 8'h03, 0, 200, "R2"); // out of range skip
    doPlot(199, 8'h03, 0, 200, "R2"); // last visible row
    setX(255);
    doPlot(255, 8'h03, 1, 255, "R2"); // out of range at max
    setX(255);
    doPlot(254, 8'h02, 0, 255, "R5"); // last column, mask 0x01, x wraps
    setX(40);
    doPlot(77, 8'h03, 0, 200, "R8", 1'b0, 1'b1); // starts while busy ignored
    doPlot(78, 8'h01, 0, 200, "R10", 1'b1);      // plot wins over read
    setX(40);
    doRead(77, 200, "R9");
    setX(41);
    doRead(78, 200, "R9");
    setX(10);
    doRead(5, 200, "R9");
    doRead(210, 200, "R2");

    bad = 0;
    for (int i = 0; i < MEM_SIZE; i++) if (ramDut[i] != ramRef[i]) bad++;
    chk(bad == 0, "R6", "untouched bytes", bad, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog run hung actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule